// File: doc/BRIEF.md
# Single-Cycle 32-bit Integer Core (Nine-Instruction Subset)

This block is a 32-bit processor that completes one instruction in every clock cycle. It fetches, decodes, executes, accesses memory and writes back all in one cycle. It supports nine instructions:

- five register-to-register operations: add, subtract, and, or, and signed set-less-than;
- a word load and a word store;
- a branch-if-equal;
- an absolute jump.

The instruction store and the data store are word-addressed arrays inside the block. Before reset is released, the environment fills both through a load port. After that, the block runs on its own from address zero.

Decoding has two levels. A main decoder turns the opcode into datapath controls and a 2-bit ALU class. A second decoder combines that class with the function field to pick the ALU operation. The current program counter, the fetched word, the register write-back and the store are brought out as observation ports, so the effect of each instruction can be seen in the cycle it executes.

Top module: `mcpu_core`

## Requirements
- R1: A synchronous active-high reset sets the PC to 0 and clears all 32 registers. While reset is high, no register or data-memory write takes place.
- R2: Every instruction other than a taken branch or a jump advances the PC by 4.
- R3: With opcode 000000, these function codes select the operation: 100000 add, 100010 subtract (rs minus rt), 100100 and, 100101 or, 101010 signed set-less-than (result 1 when rs < rt, else 0). Registers rs, rt and rd sit at instr[25:21], instr[20:16] and instr[15:11]. The result is written to rd, and wb_en_o, wb_addr_o and wb_data_o show the write in that cycle.
- R4: Opcode 100011 loads a word into rt. The byte address is rs plus the sign-extended instr[15:0]. The data word is selected by address bits [MEM_AW+1:2], and all other address bits are ignored.
- R5: Opcode 101011 stores rt to the same address form as R4. st_en_o, st_addr_o (the full byte address) and st_data_o show the store. A later load from that word returns the stored value. No register is written.
- R6: Opcode 000100 compares rs and rt. When they are equal, the next PC is PC+4 plus the sign-extended immediate shifted left by 2. Otherwise it is PC+4. No register or memory is written.
- R7: Opcode 000010 jumps to a target made of bits [31:28] of PC+4, followed by instr[25:0], followed by two zero bits.
- R8: Register 0 always reads as zero. A write aimed at it has no effect and is not shown on wb_en_o.
- R9: Any other opcode, and any opcode-000000 word whose function code is not listed in R3, writes neither a register nor memory, and the PC advances by 4.
- R10: While ld_en is high, ld_data is written at word ld_addr of the instruction memory (ld_sel = 0) or of the data memory (ld_sel = 1). instr_o shows instruction word PC[MEM_AW+1:2].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Memory load strobe |
| ld_sel | input | 1 | Load target: 0 instruction memory, 1 data memory |
| ld_addr | input | MEM_AW | Word index for the load |
| ld_data | input | 32 | Word to load |
| pc_o | output | 32 | Current program counter |
| instr_o | output | 32 | Instruction being executed |
| wb_en_o | output | 1 | Register write in this cycle |
| wb_addr_o | output | 5 | Destination register |
| wb_data_o | output | 32 | Value being written |
| st_en_o | output | 1 | Data store in this cycle |
| st_addr_o | output | 32 | Byte address of the store |
| st_data_o | output | 32 | Stored word |

## Verification
The hardest case to reach is a taken branch. It needs two registers holding equal values at exactly the moment the branch executes, and with random 32-bit register contents this almost never happens. The random programs therefore draw register fields only from r0 to r7, and they often give the branch the same register twice. Register 0 is also used often as a destination, so writes to it are exercised.

A directed program fills in the rest. It covers signed comparisons across the sign boundary, a branch that skips an instruction, a branch that falls through, a jump forward and a branch backwards, and both kinds of undecoded word.

// File: rtl/mcpu_pkg.sv
package mcpu_pkg;

    localparam int XLEN = 32;
    localparam int NREG = 32;
    localparam int RAW  = 5;

    localparam logic [5:0] OPC_REG   = 6'b000000;
    localparam logic [5:0] OPC_LOAD  = 6'b100011;
    localparam logic [5:0] OPC_STORE = 6'b101011;
    localparam logic [5:0] OPC_BEQ   = 6'b000100;
    localparam logic [5:0] OPC_JMP   = 6'b000010;

    localparam logic [5:0] FN_ADD = 6'b100000;
    localparam logic [5:0] FN_SUB = 6'b100010;
    localparam logic [5:0] FN_AND = 6'b100100;
    localparam logic [5:0] FN_OR  = 6'b100101;
    localparam logic [5:0] FN_SLT = 6'b101010;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FIELD = 2'b10
    } alu_class_e;

    typedef enum logic [3:0] {
        ALU_AND = 4'b0000,
        ALU_OR  = 4'b0001,
        ALU_ADD = 4'b0010,
        ALU_SUB = 4'b0110,
        ALU_SLT = 4'b0111
    } alu_fn_e;

    typedef struct packed {
        logic       dst_rd;
        logic       use_imm;
        logic       from_mem;
        logic       wr_reg;
        logic       rd_mem;
        logic       wr_mem;
        logic       is_beq;
        logic       is_jmp;
        alu_class_e cls;
    } ctl_t;

    function automatic logic [XLEN-1:0] sext16(input logic [15:0] v);
        return {{(XLEN-16){v[15]}}, v};
    endfunction

    function automatic logic [XLEN-1:0] jmp_target(input logic [XLEN-1:0] seq_pc,
                                                   input logic [25:0]     field);
        return {seq_pc[XLEN-1:28], field, 2'b00};
    endfunction

endpackage

// File: rtl/mcpu_ctrl.sv
module mcpu_ctrl
    import mcpu_pkg::*;
(
    input  logic [5:0] opcode,
    input  logic [5:0] funct,
    output ctl_t       ctl,
    output alu_fn_e    fn,
    output logic       fn_ok
);

    always_comb begin
        ctl     = '0;
        ctl.cls = CLS_ADD;
        case (opcode)
            OPC_REG: begin
                ctl.dst_rd = 1'b1;
                ctl.wr_reg = 1'b1;
                ctl.cls    = CLS_FIELD;
            end
            OPC_LOAD: begin
                ctl.use_imm  = 1'b1;
                ctl.from_mem = 1'b1;
                ctl.wr_reg   = 1'b1;
                ctl.rd_mem   = 1'b1;
            end
            OPC_STORE: begin
                ctl.use_imm = 1'b1;
                ctl.wr_mem  = 1'b1;
            end
            OPC_BEQ: begin
                ctl.is_beq = 1'b1;
                ctl.cls    = CLS_SUB;
            end
            OPC_JMP: ctl.is_jmp = 1'b1;
            default: ;
        endcase
    end

    always_comb begin
        fn    = ALU_ADD;
        fn_ok = 1'b1;
        case (ctl.cls)
            CLS_ADD: fn = ALU_ADD;
            CLS_SUB: fn = ALU_SUB;
            CLS_FIELD: begin
                case (funct)
                    FN_ADD:  fn = ALU_ADD;
                    FN_SUB:  fn = ALU_SUB;
                    FN_AND:  fn = ALU_AND;
                    FN_OR:   fn = ALU_OR;
                    FN_SLT:  fn = ALU_SLT;
                    default: fn_ok = 1'b0;
                endcase
            end
            default: fn_ok = 1'b0;
        endcase
    end

endmodule

// File: rtl/mcpu_regfile.sv
module mcpu_regfile
    import mcpu_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic [RAW-1:0]  ra1,
    input  logic [RAW-1:0]  ra2,
    output logic [XLEN-1:0] rd1,
    output logic [XLEN-1:0] rd2,
    input  logic            we,
    input  logic [RAW-1:0]  wa,
    input  logic [XLEN-1:0] wd
);

    logic [XLEN-1:0] regs [NREG];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we && wa != '0) begin
            regs[wa] <= wd;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs[ra2];

endmodule

// File: rtl/mcpu_alu.sv
module mcpu_alu
    import mcpu_pkg::*;
(
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  alu_fn_e         fn,
    output logic [XLEN-1:0] y,
    output logic            zero
);

    logic [XLEN-1:0] diff;
    logic            ovf;
    logic            less;

    assign diff = a - b;
    assign ovf  = (a[XLEN-1] != b[XLEN-1]) && (diff[XLEN-1] != a[XLEN-1]);
    assign less = diff[XLEN-1] ^ ovf;

    always_comb begin
        case (fn)
            ALU_AND: y = a & b;
            ALU_OR:  y = a | b;
            ALU_ADD: y = a + b;
            ALU_SUB: y = diff;
            ALU_SLT: y = {{(XLEN-1){1'b0}}, less};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);

endmodule

// File: rtl/mcpu_core.sv
module mcpu_core
    import mcpu_pkg::*;
#(
    parameter int MEM_AW = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [31:0]       ld_data,
    output logic [31:0]       pc_o,
    output logic [31:0]       instr_o,
    output logic              wb_en_o,
    output logic [4:0]        wb_addr_o,
    output logic [31:0]       wb_data_o,
    output logic              st_en_o,
    output logic [31:0]       st_addr_o,
    output logic [31:0]       st_data_o
);

    localparam int WORDS = 1 << MEM_AW;

    logic [XLEN-1:0] imem [WORDS];
    logic [XLEN-1:0] dmem [WORDS];

    logic [XLEN-1:0] pc, pc_seq, pc_next, instr;
    logic [XLEN-1:0] rs_val, rt_val, imm, opb, alu_y, mem_word, wdata;
    logic [RAW-1:0]  waddr;
    logic            alu_zero, fn_ok, reg_we, mem_we;
    ctl_t            ctl;
    alu_fn_e         fn;
    logic            unused_shamt;

    assign instr        = imem[pc[MEM_AW+1:2]];
    assign unused_shamt = ^instr[10:6];

    mcpu_ctrl u_ctrl (
        .opcode(instr[31:26]),
        .funct (instr[5:0]),
        .ctl   (ctl),
        .fn    (fn),
        .fn_ok (fn_ok)
    );

    assign waddr  = ctl.dst_rd ? instr[15:11] : instr[20:16];
    assign reg_we = ctl.wr_reg && fn_ok && !rst && (waddr != '0);
    assign mem_we = ctl.wr_mem && !rst;

    mcpu_regfile u_rf (
        .clk(clk),
        .rst(rst),
        .ra1(instr[25:21]),
        .ra2(instr[20:16]),
        .rd1(rs_val),
        .rd2(rt_val),
        .we (reg_we),
        .wa (waddr),
        .wd (wdata)
    );

    assign imm = sext16(instr[15:0]);
    assign opb = ctl.use_imm ? imm : rt_val;

    mcpu_alu u_alu (
        .a   (rs_val),
        .b   (opb),
        .fn  (fn),
        .y   (alu_y),
        .zero(alu_zero)
    );

    assign mem_word = ctl.rd_mem ? dmem[alu_y[MEM_AW+1:2]] : '0;
    assign wdata    = ctl.from_mem ? mem_word : alu_y;

    assign pc_seq = pc + 32'd4;

    always_comb begin
        pc_next = pc_seq;
        if (ctl.is_beq && alu_zero) pc_next = pc_seq + {imm[XLEN-3:0], 2'b00};
        if (ctl.is_jmp)             pc_next = jmp_target(pc_seq, instr[25:0]);
    end

    always_ff @(posedge clk) begin
        if (rst) pc <= '0;
        else     pc <= pc_next;
    end

    always_ff @(posedge clk) begin
        if (ld_en && !ld_sel) imem[ld_addr] <= ld_data;
    end

    always_ff @(posedge clk) begin
        if (ld_en && ld_sel)  dmem[ld_addr] <= ld_data;
        else if (mem_we)      dmem[alu_y[MEM_AW+1:2]] <= rt_val;
    end

    assign pc_o      = pc;
    assign instr_o   = instr;
    assign wb_en_o   = reg_we;
    assign wb_addr_o = waddr;
    assign wb_data_o = wdata;
    assign st_en_o   = mem_we;
    assign st_addr_o = alu_y;
    assign st_data_o = rt_val;

endmodule

// File: rtl/mcpu_core_chk.sv
module mcpu_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] pc_o,
    input logic [31:0] instr_o,
    input logic        wb_en_o,
    input logic [4:0]  wb_addr_o,
    input logic        st_en_o
);

    logic [31:0] pc4;
    logic [5:0]  op;
    logic        known;

    assign pc4   = pc_o + 32'd4;
    assign op    = instr_o[31:26];
    assign known = (op == 6'b000000) || (op == 6'b100011) || (op == 6'b101011) ||
                   (op == 6'b000100) || (op == 6'b000010);

    p_pc_zero_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> pc_o == 32'd0);

    p_pc_step_r2: assert property (@(posedge clk) disable iff (rst)
        (op != 6'b000100 && op != 6'b000010) |=> pc_o == $past(pc4));

    p_store_no_wb_r5: assert property (@(posedge clk) disable iff (rst)
        st_en_o |-> !wb_en_o);

    p_jump_target_r7: assert property (@(posedge clk) disable iff (rst)
        (op == 6'b000010) |=>
            pc_o == {$past(pc4[31:28]), $past(instr_o[25:0]), 2'b00});

    p_zero_reg_r8: assert property (@(posedge clk) disable iff (rst)
        wb_en_o |-> wb_addr_o != 5'd0);

    p_unknown_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        !known |-> (!wb_en_o && !st_en_o));

endmodule

bind mcpu_core mcpu_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .pc_o     (pc_o),
    .instr_o  (instr_o),
    .wb_en_o  (wb_en_o),
    .wb_addr_o(wb_addr_o),
    .st_en_o  (st_en_o)
);

// File: tb/sim_mcpu_core.sv
module sim_mcpu_core;

    localparam int AW    = 6;
    localparam int WORDS = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic          ld_sel = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [31:0]   pc_o, instr_o, wb_data_o, st_addr_o, st_data_o;
    logic          wb_en_o, st_en_o;
    logic [4:0]    wb_addr_o;

    always #4 clk = ~clk;

    mcpu_core #(.MEM_AW(AW)) u0 (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_sel(ld_sel),
        .ld_addr(ld_addr), .ld_data(ld_data),
        .pc_o(pc_o), .instr_o(instr_o),
        .wb_en_o(wb_en_o), .wb_addr_o(wb_addr_o), .wb_data_o(wb_data_o),
        .st_en_o(st_en_o), .st_addr_o(st_addr_o), .st_data_o(st_data_o)
    );

    logic [31:0] m_im [WORDS];
    logic [31:0] m_dm [WORDS];
    logic [31:0] m_rf [32];
    logic [31:0] m_pc;
    string       ptag;
    int          n_cmp = 0;
    int          n_bad = 0;
    bit          done  = 1'b0;

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h (pc %h)", tag, what, act, exp, m_pc);
        end
    endtask

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input int rs, input int rt, input int rd);
        return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] rand_instr();
        int k  = int'($urandom_range(0, 15));
        int rs = int'($urandom_range(0, 7));
        int rt = int'($urandom_range(0, 7));
        int rd = int'($urandom_range(0, 7));
        int im = int'($urandom_range(0, 511)) - 256;
        logic [5:0] fns [5] = '{6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
        case (k)
            0, 1, 2, 3, 4, 5: return enc_r(fns[k % 5], rs, rt, rd);
            6:      return enc_r(6'h03, rs, rt, rd);
            7, 8:   return enc_i(6'h23, rs, rt, im);
            9, 10:  return enc_i(6'h2B, rs, rt, im);
            11, 12: return enc_i(6'h04, rs, ($urandom_range(0, 1) == 1) ? rs : rt,
                                 int'($urandom_range(0, 8)) - 4);
            13:     return {6'b000010, 26'($urandom_range(0, WORDS - 1))};
            14:     return {6'b001000, 26'($urandom)};
            default: return enc_r(6'h20, rs, rt, rd);
        endcase
    endfunction

    // Reference step: compare outputs for the current instruction, then commit.
    task automatic step_cmp();
        logic [31:0] ins, a, b, se, res, npc, pc4, ea;
        logic [5:0]  op, fn;
        int          rs, rt, rd;
        logic        e_wb, e_st, ok;
        logic [4:0]  e_wa;
        logic [31:0] e_wd;
        string       tag;
        ins = m_im[m_pc[AW+1:2]];
        chk("R10", "instr_o", instr_o, ins);
        chk(ptag, "pc_o", pc_o, m_pc);
        op = ins[31:26]; fn = ins[5:0];
        rs = int'(ins[25:21]); rt = int'(ins[20:16]); rd = int'(ins[15:11]);
        a = m_rf[rs]; b = m_rf[rt];
        se = {{16{ins[15]}}, ins[15:0]};
        pc4 = m_pc + 32'd4; npc = pc4;
        e_wb = 1'b0; e_st = 1'b0; e_wa = '0; e_wd = '0; ea = '0;
        tag = "R9";
        case (op)
            6'b000000: begin
                ok = 1'b1; res = '0;
                case (fn)
                    6'h20: res = a + b;
                    6'h22: res = a - b;
                    6'h24: res = a & b;
                    6'h25: res = a | b;
                    6'h2A: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: ok = 1'b0;
                endcase
                if (ok) begin
                    tag = (rd == 0) ? "R8" : "R3";
                    e_wb = (rd != 0); e_wa = 5'(rd); e_wd = res;
                end
            end
            6'b100011: begin
                ea = a + se;
                tag = (rt == 0) ? "R8" : "R4";
                e_wb = (rt != 0); e_wa = 5'(rt); e_wd = m_dm[ea[AW+1:2]];
            end
            6'b101011: begin
                ea = a + se; tag = "R5"; e_st = 1'b1;
            end
            6'b000100: begin
                tag = "R6";
                if (a == b) npc = pc4 + {se[29:0], 2'b00};
            end
            6'b000010: begin
                tag = "R7";
                npc = {pc4[31:28], ins[25:0], 2'b00};
            end
            default: tag = "R9";
        endcase
        chk(tag, "wb_en_o", {31'd0, wb_en_o}, {31'd0, e_wb});
        if (e_wb) begin
            chk(tag, "wb_addr_o", {27'd0, wb_addr_o}, {27'd0, e_wa});
            chk(tag, "wb_data_o", wb_data_o, e_wd);
        end
        chk(tag, "st_en_o", {31'd0, st_en_o}, {31'd0, e_st});
        if (e_st) begin
            chk(tag, "st_addr_o", st_addr_o, ea);
            chk(tag, "st_data_o", st_data_o, b);
        end
        if (e_wb) m_rf[e_wa] = e_wd;
        if (e_st) m_dm[ea[AW+1:2]] = b;
        ptag = (op == 6'b000100 || op == 6'b000010) ? tag : "R2";
        m_pc = npc;
    endtask

    task automatic load_and_reset();
        rst = 1'b1;
        for (int i = 0; i < 2 * WORDS; i++) begin
            @(negedge clk);
            ld_en   = 1'b1;
            ld_sel  = (i >= WORDS);
            ld_addr = AW'(i % WORDS);
            ld_data = (i >= WORDS) ? m_dm[i - WORDS] : m_im[i];
        end
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        chk("R1", "pc_o in reset", pc_o, 32'd0);
        chk("R1", "wb_en_o in reset", {31'd0, wb_en_o}, 32'd0);
        chk("R1", "st_en_o in reset", {31'd0, st_en_o}, 32'd0);
        for (int i = 0; i < 32; i++) m_rf[i] = '0;
        m_pc = '0;
        ptag = "R1";
        rst  = 1'b0;
        #1;
    endtask

    task automatic run(input int n);
        for (int c = 0; c < n; c++) begin
            step_cmp();
            @(negedge clk);
            #1;
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        // Directed program
        for (int i = 0; i < WORDS; i++) begin
            m_im[i] = 32'd0;          // funct 000000: undecoded, acts as no-op
            m_dm[i] = $urandom;
        end
        m_dm[0] = 32'h8000_0005;
        m_dm[1] = 32'h0000_0007;
        m_im[0]  = enc_i(6'h23, 0, 1, 0);        // lw r1,0(r0)
        m_im[1]  = enc_i(6'h23, 0, 2, 4);        // lw r2,4(r0)
        m_im[2]  = enc_r(6'h20, 1, 2, 0);        // add r0 (R8)
        m_im[3]  = enc_r(6'h20, 0, 1, 3);        // r3 = r0 + r1
        m_im[4]  = enc_r(6'h2A, 1, 2, 4);        // slt negative < positive
        m_im[5]  = enc_r(6'h2A, 2, 1, 5);        // slt positive < negative
        m_im[6]  = enc_r(6'h22, 2, 1, 6);        // sub with wrap
        m_im[7]  = enc_r(6'h24, 1, 2, 7);
        m_im[8]  = enc_r(6'h25, 1, 2, 9);
        m_im[9]  = enc_i(6'h2B, 0, 6, 8);        // sw r6,8(r0)
        m_im[10] = enc_i(6'h23, 0, 10, 8);       // lw back (R5)
        m_im[11] = enc_i(6'h04, 1, 3, 1);        // beq taken, skip 12
        m_im[12] = enc_r(6'h20, 1, 1, 11);
        m_im[13] = enc_i(6'h04, 1, 2, 5);        // beq not taken
        m_im[14] = enc_r(6'h03, 1, 2, 12);       // undecoded funct
        m_im[15] = enc_i(6'h08, 1, 13, 99);      // undecoded opcode
        m_im[16] = {6'b000010, 26'd18};          // j 18
        m_im[17] = enc_r(6'h20, 1, 1, 14);
        m_im[18] = enc_i(6'h04, 0, 0, -19);      // back to 0
        load_and_reset();
        run(60);
        // Random programs
        for (int p = 0; p < 3; p++) begin
            for (int i = 0; i < WORDS; i++) begin
                m_im[i] = rand_instr();
                m_dm[i] = (i % 3 == 0) ? 32'(i) : $urandom;
            end
            load_and_reset();
            run(1500);
        end
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule